// File: doc/BRIEF.md
# Pad Receive Conditioning Path

This block takes the receive signal of a single pad and turns it into the three values the rest of the chip consumes: a state for software readback, a state handed to the native peripheral functions sharing the pad, and an event line for the interrupt logic. The raw input first passes a gate that forces it low when the receive buffer is disabled, or high when a force-high override is set. It is then brought into the clock domain by a synchronizer and passed through a stability-based glitch filter.

A chain of multiplexers follows, and each output takes its value from a different point in that chain. The readback output sees only the filtered value. The native output can take either the raw gated input or the conditioned internal state. The event output can present the conditioned state as a level, as a pulse on rising transitions, as a pulse on any transition, or not at all. Configuration inputs are applied directly, with no register decode.

Top module: `pad_rx_cond`

## Requirements
- R1: While `rxDisable` is 1, the gated input is 0. `readState` reads 0 in that cycle, and with `nativeSel`=0 `nativeState` is 0 as well.
- R2: When `forceOne` is 1 and `rxDisable` is 0, the gated input is 1 whatever `padIn` is. This is applied before the synchronizer, the filter and the inversion stage.
- R3: The gated input passes through a two-flop synchronizer. A change becomes visible on the unfiltered tap after the second rising clock edge.
- R4: The filtered value takes the synchronized value only after the two have differed for FILT_CYCLES consecutive cycles (default 3). A shorter disagreement leaves the filtered value unchanged.
- R5: `useFiltered`=0 selects the synchronized unfiltered value as the internal state. `useFiltered`=1 selects the filtered value.
- R6: `readState` equals the filtered value. It is not affected by `invertEn`, `useFiltered`, `nativeSel` or `eventMode`.
- R7: `invertEn`=1 inverts the internal state seen by the event output and by the native output when `nativeSel`=1. It does not invert `readState`.
- R8: `nativeSel`=0 gives the gated input on `nativeState` combinationally, with no synchronizer delay. `nativeSel`=1 gives the inverted-stage internal state.
- R9: `eventMode`=0 (level) drives `eventOut` with the inverted-stage state.
- R10: `eventMode`=1 (edge) pulses `eventOut` for exactly one cycle when the inverted-stage state goes from 0 to 1.
- R11: `eventMode`=3 (either edge) pulses `eventOut` for one cycle on every change of the inverted-stage state.
- R12: `eventMode`=2 (disabled) holds `eventOut` at 0.
- R13: After reset, with `padIn`=0 and `invertEn`=0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| padIn | input | 1 | Raw pad receive signal |
| rxDisable | input | 1 | Receive buffer disable; forces the gated input to 0 |
| forceOne | input | 1 | Override that forces the gated input to 1 |
| useFiltered | input | 1 | Internal state source: 0 unfiltered, 1 filtered |
| nativeSel | input | 1 | Native output source: 0 raw gated, 1 internal |
| invertEn | input | 1 | Polarity inversion of the internal state |
| eventMode | input | 2 | 0 level, 1 rising edge, 2 off, 3 either edge |
| readState | output | 1 | Software readback state |
| nativeState | output | 1 | State delivered to native functions |
| eventOut | output | 1 | Level or single-cycle pulse to the interrupt logic |

## Verification
The pulse-width assertion for edge mode is only meaningful while the event mode stays constant across consecutive cycles, so it checks only cycles where the mode has not changed. The disabled-mode assertion likewise relies on the mode input being stable for the whole cycle. To respect both conditions, the stimulus changes configuration only on falling clock edges. It also holds the mode steady across each run of pad toggles. Glitch pulses are deliberately made shorter than the filter window, and steady levels longer than it, so that both the suppression and the update sides of the filter are exercised.

// File: rtl/pad_rx_pkg.sv
package pad_rx_pkg;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_EDGE  = 2'd1,
    EV_OFF   = 2'd2,
    EV_BOTH  = 2'd3
  } evMode_e;

  typedef struct packed {
    logic gateZero;
    logic forceHigh;
    logic pickFiltered;
    logic flipPolarity;
    logic nativeInternal;
    logic evLevel;
    logic evRise;
    logic evAny;
  } condStrobe_t;

endpackage

// File: rtl/pad_rx_ctrl.sv
module pad_rx_ctrl
  import pad_rx_pkg::*;
(
  input  logic        rxDisable,
  input  logic        forceOne,
  input  logic        useFiltered,
  input  logic        nativeSel,
  input  logic        invertEn,
  input  logic [1:0]  eventMode,
  output condStrobe_t strobe
);

  evMode_e modeDec;

  always_comb begin
    modeDec               = evMode_e'(eventMode);
    strobe                = '0;
    strobe.gateZero       = rxDisable;
    strobe.forceHigh      = forceOne & ~rxDisable;
    strobe.pickFiltered   = useFiltered;
    strobe.flipPolarity   = invertEn;
    strobe.nativeInternal = nativeSel;
    case (modeDec)
      EV_LEVEL: strobe.evLevel = 1'b1;
      EV_EDGE:  strobe.evRise  = 1'b1;
      EV_BOTH:  strobe.evAny   = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/pad_rx_datapath.sv
module pad_rx_datapath
  import pad_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        padIn,
  input  condStrobe_t strobe,
  output logic        readState,
  output logic        nativeState,
  output logic        eventOut
);

  localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYCLES - 1);

  logic gatedIn;
  logic [SYNC_STAGES-1:0] syncChain;
  logic syncOut;
  logic filtOut;
  logic [CW-1:0] stableCnt;
  logic selState;
  logic invState;
  logic prevInv;

  assign gatedIn = strobe.gateZero ? 1'b0 : (strobe.forceHigh | padIn);

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[i] <= 1'b0;
        else if (i == 0) syncChain[i] <= gatedIn;
        else syncChain[i] <= syncChain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign syncOut = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtOut   <= 1'b0;
      stableCnt <= '0;
    end else if (syncOut == filtOut) begin
      stableCnt <= '0;
    end else if (stableCnt == CNT_LAST) begin
      filtOut   <= syncOut;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  assign selState    = strobe.pickFiltered ? filtOut : syncOut;
  assign invState    = selState ^ strobe.flipPolarity;
  assign readState   = strobe.gateZero ? 1'b0 : filtOut;
  assign nativeState = strobe.nativeInternal ? invState : gatedIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevInv <= 1'b0;
    else prevInv <= invState;
  end

  always_comb begin
    eventOut = 1'b0;
    if (strobe.evLevel)     eventOut = invState;
    else if (strobe.evRise) eventOut = invState & ~prevInv;
    else if (strobe.evAny)  eventOut = invState ^ prevInv;
  end

  AST_FILTER_TAKES_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (filtOut != $past(filtOut)) |-> (filtOut == $past(syncOut))); // R4

  AST_FILTER_HOLDS_ON_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(syncOut) == $past(filtOut)) |-> (filtOut == $past(filtOut))); // R4

endmodule

// File: rtl/pad_rx_cond.sv
module pad_rx_cond
  import pad_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       padIn,
  input  logic       rxDisable,
  input  logic       forceOne,
  input  logic       useFiltered,
  input  logic       nativeSel,
  input  logic       invertEn,
  input  logic [1:0] eventMode,
  output logic       readState,
  output logic       nativeState,
  output logic       eventOut
);

  condStrobe_t strobe;
  logic armed;

  pad_rx_ctrl u_ctrl (
    .rxDisable  (rxDisable),
    .forceOne   (forceOne),
    .useFiltered(useFiltered),
    .nativeSel  (nativeSel),
    .invertEn   (invertEn),
    .eventMode  (eventMode),
    .strobe     (strobe)
  );

  pad_rx_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_CYCLES(FILT_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .padIn      (padIn),
    .strobe     (strobe),
    .readState  (readState),
    .nativeState(nativeState),
    .eventOut   (eventOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else armed <= 1'b1;
  end

  AST_DISABLED_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rxDisable |-> !readState); // R1

  AST_OFF_MODE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (eventMode == 2'd2) |-> !eventOut); // R12

  AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (armed && eventMode == 2'd1 && $past(eventMode) == 2'd1 && $past(eventOut))
      |-> !eventOut); // R10

  AST_RAW_NATIVE_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    (!nativeSel && forceOne && !rxDisable) |-> nativeState); // R2

endmodule

// File: tb/pad_rx_cond_test.sv
module pad_rx_cond_test;

  localparam int FILT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic padIn = 1'b0, rxDisable = 1'b0, forceOne = 1'b0;
  logic useFiltered = 1'b0, nativeSel = 1'b0, invertEn = 1'b0;
  logic [1:0] eventMode = 2'd0;
  logic readState, nativeState, eventOut;

  int nTests = 0;
  int nFail = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  int mS1 = 0, mS2 = 0, mFilt = 0, mCnt = 0, mPrev = 0;

  always #5 clk = ~clk;

  pad_rx_cond #(.SYNC_STAGES(2), .FILT_CYCLES(FILT)) uut (
    .clk(clk), .rstN(rstN), .padIn(padIn), .rxDisable(rxDisable),
    .forceOne(forceOne), .useFiltered(useFiltered), .nativeSel(nativeSel),
    .invertEn(invertEn), .eventMode(eventMode), .readState(readState),
    .nativeState(nativeState), .eventOut(eventOut)
  );

  function automatic int gated();
    if (rxDisable) return 0;
    if (forceOne) return 1;
    return int'(padIn);
  endfunction

  function automatic int invTap();
    int s;
    s = useFiltered ? mFilt : mS2;
    return s ^ int'(invertEn);
  endfunction

  function automatic int expEvent();
    case (eventMode)
      2'd0: return invTap();
      2'd1: return (invTap() == 1 && mPrev == 0) ? 1 : 0;
      2'd3: return (invTap() != mPrev) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mFilt = 0; mCnt = 0; mPrev = 0;
    end else begin
      int g, i;
      g = gated();
      i = invTap();
      if (mS2 == mFilt) mCnt = 0;
      else if (mCnt == FILT - 1) begin mFilt = mS2; mCnt = 0; end
      else mCnt = mCnt + 1;
      mS2 = mS1;
      mS1 = g;
      mPrev = i;
    end
  end

  task automatic check(string tag, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic evTag(output string t);
    case (eventMode)
      2'd0: t = "R9 event level";
      2'd1: t = "R10 event edge";
      2'd3: t = "R11 event either";
      default: t = "R12 event off";
    endcase
  endtask

  // advance one clock and compare all outputs against the model
  task automatic step();
    string t;
    @(negedge clk);
    check("R6 readState", int'(readState), rxDisable ? 0 : mFilt);
    check("R8 nativeState", int'(nativeState), nativeSel ? invTap() : gated());
    evTag(t);
    check(t, int'(eventOut), expEvent());
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    // R13 reset state
    check("R13 reset readState", int'(readState), 0);
    check("R13 reset eventOut", int'(eventOut), 0);
    check("R13 reset nativeState", int'(nativeState), 0);

    // R3 synchronizer latency via unfiltered level path
    nativeSel = 1; useFiltered = 0; eventMode = 2'd0;
    padIn = 1;
    step(); check("R3 after one edge", int'(eventOut), 0);
    step(); check("R3 after two edges", int'(eventOut), 1);
    // R4 filter settles after FILT further cycles
    step(); step(); check("R4 not yet filtered", int'(readState), 0);
    step(); check("R4 filtered update", int'(readState), 1);
    run(3);

    // R4 short glitch low suppressed
    padIn = 0; step(); step();
    padIn = 1;
    run(6);
    check("R4 glitch suppressed", int'(readState), 1);

    // R5 filtered vs unfiltered source with R7 inversion
    useFiltered = 1; invertEn = 1;
    step();
    check("R7 invert event", int'(eventOut), 0);
    check("R7 readback not inverted", int'(readState), 1);
    useFiltered = 0; padIn = 0; run(2);
    check("R5 unfiltered tracks", int'(eventOut), 1);
    useFiltered = 1; step();
    check("R5 filtered lags", int'(eventOut), 0);
    run(4);
    invertEn = 0;

    // R1 disable gating and R2 force
    rxDisable = 1; nativeSel = 0; padIn = 1; step();
    check("R1 read zero", int'(readState), 0);
    check("R1 native zero", int'(nativeState), 0);
    rxDisable = 0; forceOne = 1; padIn = 0; step();
    check("R2 native forced", int'(nativeState), 1);
    run(8);
    check("R2 forced filtered", int'(readState), 1);
    forceOne = 0; run(8);

    // event modes over pad toggles
    for (int m = 0; m < 4; m++) begin
      eventMode = 2'(m);
      for (int inv = 0; inv < 2; inv++) begin
        invertEn = inv[0];
        for (int uf = 0; uf < 2; uf++) begin
          useFiltered = uf[0];
          for (int k = 0; k < 24; k++) begin
            padIn = ((k / 5) % 2 == 1) || (k == 2);
            nativeSel = k[0];
            step();
          end
        end
      end
    end
    // R10 explicit single pulse
    eventMode = 2'd1; invertEn = 0; useFiltered = 0; padIn = 0; run(6);
    padIn = 1; run(2);
    check("R10 pulse high", int'(eventOut), 1);
    step(); check("R10 pulse ends", int'(eventOut), 0);
    // R11 falling also pulses
    eventMode = 2'd3; padIn = 0; run(2);
    check("R11 fall pulse", int'(eventOut), 1);
    // R12 off mode
    eventMode = 2'd2; padIn = 1; run(3);
    check("R12 off silent", int'(eventOut), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule